// File: doc/BRIEF.md
# Firmware Hub Read-Cycle Target

This block is the target side of a 4-bit multiplexed firmware-hub bus, limited to single-byte reads. It watches an active-low frame strobe and the shared nibble lines. It recognises a read opener and checks the one-clock device-select nibble against four strap inputs. It then gathers a seven-nibble address and ignores the size nibble. After that it takes over the lines and returns one byte from a synchronous byte-wide read port.

Every field sits in a fixed clock slot, counted from the clock in which the frame strobe is low with the opener on the lines. The target leaves the lines undriven up to and including clock 11 and owns them from clock 12 to clock 18. In clock 19 it floats the lines again. The read port receives a one-clock strobe in clock 10 and presents the byte one clock later.

Top module: `fwh_read_target`

## Requirements
- R1: While reset is asserted and after it is released, with no frame activity, `bus_oe` and `mem_rd` are 0.
- R2: A transaction begins only when `frame_n` is 0 and the nibble is 1101b in that clock (clock 1). Any other nibble with `frame_n` low leaves the block idle, and it never drives the lines for that frame.
- R3: The nibble in clock 2 is compared with `id_strap`. On a mismatch the block does not respond at all (`bus_oe` stays 0 and `mem_rd` stays 0).
- R4: Clocks 3 to 9 carry the address, most significant nibble first. In clock 10 `mem_rd` is 1 for exactly one clock, and `mem_addr` equals the low `ADDR_W` bits of the address.
- R5: The block leaves the lines undriven in clocks 1 to 11, so it never overlaps with the host. In clock 12 it drives 1111b.
- R6: In clocks 13 and 14 the block drives the wait code 0101b. In clock 15 it drives the ready code 0000b.
- R7: Clock 16 carries the low nibble of the byte returned by the read port, and clock 17 carries the high nibble.
- R8: In clock 18 the block drives 1111b. In clock 19 `bus_oe` is 0.
- R9: If `frame_n` goes low in any clock of an ongoing transaction, `bus_oe` is 0 from the next clock on. If that nibble is 1101b, the clock counts as clock 1 of a new transaction.
- R10: The size nibble in clock 10 has no effect. Exactly one byte is returned, and the lines are undriven after clock 19.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_n | input | 1 | Active-low frame strobe from the host |
| bus_in | input | 4 | Resolved value of the shared nibble lines |
| id_strap | input | 4 | Device-select strap value |
| bus_out | output | 4 | Nibble driven onto the shared lines |
| bus_oe | output | 1 | Drive enable for the shared lines |
| mem_addr | output | ADDR_W | Byte address to the read port |
| mem_rd | output | 1 | One-clock read strobe to the read port |
| mem_rdata | input | 8 | Byte from the read port, valid the clock after `mem_rd` |

## Verification
Results fall due at fixed clock counts after the opener. The read strobe and the address are due in clock 10, and no drive is allowed through clock 11. The turnaround, the two wait codes and the ready code are due in clocks 12 to 15, the data nibbles in clocks 16 and 17, and the final turnaround and release in clocks 18 and 19. After a late frame strobe, release is due one clock later. The bench steps the host through these clocks one at a time: it drives at the falling edge, and at that same point it samples outputs that depend only on state registered at the rising edge before. Each check is therefore tied to its numbered clock, with no search window.

// File: rtl/fwh_pkg.sv
package fwh_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_ID, S_ADDR, S_MSIZE, S_TAR1, S_TAR2,
    S_WSYNC, S_RSYNC, S_DLO, S_DHI, S_TARA
  } fwh_st_e;

  localparam logic [3:0] NIB_START = 4'hD;
  localparam logic [3:0] NIB_WAIT  = 4'h5;
  localparam logic [3:0] NIB_READY = 4'h0;
  localparam logic [3:0] NIB_TURN  = 4'hF;

  // pick one nibble of a byte, low half when hi is 0
  function automatic logic [3:0] nib_of(input logic [7:0] b, input logic hi);
    return hi ? b[7:4] : b[3:0];
  endfunction

  // states in which the target owns the shared lines
  function automatic logic owns_bus(input fwh_st_e s);
    return (s == S_TAR2) || (s == S_WSYNC) || (s == S_RSYNC) ||
           (s == S_DLO)  || (s == S_DHI)   || (s == S_TARA);
  endfunction

endpackage

// File: rtl/fwh_hdr_capture.sv
module fwh_hdr_capture #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_addr,
  input  logic [3:0]        bus_in,
  input  logic [3:0]        id_strap,
  output logic              id_hit,
  output logic [ADDR_W-1:0] addr_q
);

  // comparison used by the sequencer in the select clock
  assign id_hit = (bus_in == id_strap);

  // most significant nibble arrives first; upper bits fall off the top
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        addr_q <= '0;
    else if (cap_addr) addr_q <= ADDR_W'({addr_q, bus_in});
  end

endmodule

// File: rtl/fwh_seq.sv
module fwh_seq
  import fwh_pkg::*;
#(
  parameter int ADDR_NIB = 7,
  parameter int WAIT_N   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_n,
  input  logic [3:0] bus_in,
  input  logic       id_hit,
  output fwh_st_e    st,
  output logic       cap_addr,
  output logic       rd_strobe,
  output logic       data_cap
);

  localparam int CNT_MAX = (ADDR_NIB > WAIT_N) ? ADDR_NIB : WAIT_N;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_NIB - 1);
  localparam logic [CNT_W-1:0] WAIT_LAST = CNT_W'(WAIT_N - 1);

  fwh_st_e          nxt;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    nxt = st;
    if (!frame_n) begin
      // a low strobe opens a frame or cuts the current one
      nxt = (bus_in == NIB_START) ? S_ID : S_IDLE;
    end else begin
      unique case (st)
        S_IDLE:  nxt = S_IDLE;
        S_ID:    nxt = id_hit ? S_ADDR : S_IDLE;
        S_ADDR:  nxt = (cnt == ADDR_LAST) ? S_MSIZE : S_ADDR;
        S_MSIZE: nxt = S_TAR1;
        S_TAR1:  nxt = S_TAR2;
        S_TAR2:  nxt = S_WSYNC;
        S_WSYNC: nxt = (cnt == WAIT_LAST) ? S_RSYNC : S_WSYNC;
        S_RSYNC: nxt = S_DLO;
        S_DLO:   nxt = S_DHI;
        S_DHI:   nxt = S_TARA;
        S_TARA:  nxt = S_IDLE;
        default: nxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      st  <= nxt;
      cnt <= (nxt != st) ? '0 : cnt + 1'b1;
    end
  end

  assign cap_addr  = (st == S_ADDR) && frame_n;
  assign rd_strobe = (st == S_MSIZE);
  assign data_cap  = (st == S_TAR1);

endmodule

// File: rtl/fwh_drive.sv
module fwh_drive
  import fwh_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  fwh_st_e    st,
  input  logic       data_cap,
  input  logic [7:0] mem_rdata,
  output logic [3:0] bus_out,
  output logic       bus_oe
);

  logic [7:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        data_q <= '0;
    else if (data_cap) data_q <= mem_rdata;
  end

  assign bus_oe = owns_bus(st);

  always_comb begin
    unique case (st)
      S_WSYNC: bus_out = NIB_WAIT;
      S_RSYNC: bus_out = NIB_READY;
      S_DLO:   bus_out = nib_of(data_q, 1'b0);
      S_DHI:   bus_out = nib_of(data_q, 1'b1);
      default: bus_out = NIB_TURN;
    endcase
  end

endmodule

// File: rtl/fwh_read_target.sv
module fwh_read_target
  import fwh_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int ADDR_NIB = 7,
  parameter int WAIT_N   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic [3:0]        bus_in,
  input  logic [3:0]        id_strap,
  output logic [3:0]        bus_out,
  output logic              bus_oe,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  input  logic [7:0]        mem_rdata
);

  // named internal events, observed by the bound checker
  fwh_st_e st;
  logic    id_hit;
  logic    cap_addr;
  logic    data_cap;

  fwh_seq #(.ADDR_NIB(ADDR_NIB), .WAIT_N(WAIT_N)) u_seq (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .bus_in(bus_in),
    .id_hit(id_hit), .st(st), .cap_addr(cap_addr),
    .rd_strobe(mem_rd), .data_cap(data_cap)
  );

  fwh_hdr_capture #(.ADDR_W(ADDR_W)) u_hdr (
    .clk(clk), .rst_n(rst_n), .cap_addr(cap_addr), .bus_in(bus_in),
    .id_strap(id_strap), .id_hit(id_hit), .addr_q(mem_addr)
  );

  fwh_drive u_drv (
    .clk(clk), .rst_n(rst_n), .st(st), .data_cap(data_cap),
    .mem_rdata(mem_rdata), .bus_out(bus_out), .bus_oe(bus_oe)
  );

endmodule

// File: rtl/fwh_read_target_chk.sv
module fwh_read_target_chk
  import fwh_pkg::*;
(
  input logic    clk,
  input logic    rst_n,
  input logic    frame_n,
  input logic    bus_oe,
  input logic    mem_rd,
  input fwh_st_e st,
  input logic    id_hit
);

  AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd); // R4

  AST_TAR1_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !bus_oe); // R5

  AST_ID_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ID && frame_n && !id_hit) |=> (st == S_IDLE)); // R3

  AST_READY_TO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RSYNC && frame_n) |=> (st == S_DLO && bus_oe)); // R7

  AST_TAR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TARA && frame_n) |=> !bus_oe); // R8

  AST_ABORT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |=> !bus_oe); // R9

endmodule

bind fwh_read_target fwh_read_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .bus_oe(bus_oe),
  .mem_rd(mem_rd), .st(st), .id_hit(id_hit)
);

// File: tb/fwh_read_target_tb.sv
module fwh_read_target_tb;

  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frame_n = 1'b1;
  logic          host_oe = 1'b0;
  logic [3:0]    host_val = 4'hF;
  logic [3:0]    strap = 4'hA;
  logic [3:0]    bus_out;
  logic          bus_oe;
  logic [AW-1:0] mem_addr;
  logic          mem_rd;
  logic [7:0]    mem_q = '0;
  logic [3:0]    bus_wire;
  int            n_chk = 0;
  int            n_fail = 0;

  always #2 clk = ~clk;

  // shared lines with a pull-up when nobody drives
  assign bus_wire = bus_oe ? bus_out : (host_oe ? host_val : 4'hF);

  function automatic logic [7:0] ref_byte(input logic [7:0] a);
    return (a * 8'd29 + 8'h5B) ^ {a[2:0], a[7:3]};
  endfunction

  always_ff @(posedge clk) if (mem_rd) mem_q <= ref_byte(mem_addr);

  fwh_read_target #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .bus_in(bus_wire),
    .id_strap(strap), .bus_out(bus_out), .bus_oe(bus_oe),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_q)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic see(input logic eoe, input logic [3:0] ev, input string tag);
    chk(bus_oe == eoe && (!eoe || bus_out == ev), tag,
        {bus_oe, bus_out}, {eoe, ev});
  endtask

  // one bus clock: drive at the falling edge, outputs are state-only
  task automatic cyc(input logic fr, input logic hoe, input logic [3:0] hv);
    @(negedge clk);
    frame_n = fr; host_oe = hoe; host_val = hv;
    if (hoe && bus_oe) chk(1'b0, "R5 overlap", 1, 0);
  endtask

  task automatic read_txn(input logic [3:0] st_nib, input logic [3:0] idsel,
                          input logic [27:0] addr, input logic [3:0] msize,
                          input bit resp, input string tag, input int last);
    logic [7:0] eb;
    eb = ref_byte(addr[AW-1:0]);
    cyc(1'b0, 1'b1, st_nib);  see(1'b0, 4'h0, "R5 clk1");
    cyc(1'b1, 1'b1, idsel);
    for (int i = 0; i < 7; i++) begin
      if (3 + i > last) return;
      cyc(1'b1, 1'b1, addr[4*(6-i) +: 4]);
    end
    if (last < 10) return;
    cyc(1'b1, 1'b1, msize);
    chk(mem_rd == resp, {tag, " R4 rd"}, mem_rd, resp);
    if (resp) chk(mem_addr == addr[AW-1:0], "R4 addr", mem_addr, addr[AW-1:0]);
    cyc(1'b1, 1'b1, 4'hF);
    see(1'b0, 4'h0, "R5 clk11");
    chk(!mem_rd, "R4 single", mem_rd, 0);
    cyc(1'b1, 1'b0, 4'hF); see(resp, 4'hF, {tag, " R5 clk12"});
    if (last < 13) return;
    cyc(1'b1, 1'b0, 4'hF); see(resp, 4'h5, {tag, " R6 wait1"});
    if (last < 14) return;
    cyc(1'b1, 1'b0, 4'hF); see(resp, 4'h5, {tag, " R6 wait2"});
    if (last < 15) return;
    cyc(1'b1, 1'b0, 4'hF); see(resp, 4'h0, {tag, " R6 ready"});
    cyc(1'b1, 1'b0, 4'hF); see(resp, eb[3:0], {tag, " R7 low"});
    cyc(1'b1, 1'b0, 4'hF); see(resp, eb[7:4], {tag, " R7 high"});
    cyc(1'b1, 1'b0, 4'hF); see(resp, 4'hF, {tag, " R8 turn"});
    cyc(1'b1, 1'b0, 4'hF); see(1'b0, 4'h0, {tag, " R8 release"});
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!bus_oe && !mem_rd, "R1 in reset", {bus_oe, mem_rd}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!bus_oe && !mem_rd, "R1 after reset", {bus_oe, mem_rd}, 0);

    // every strap against every select value
    for (int s = 0; s < 16; s++) begin
      strap = 4'(s);
      for (int d = 0; d < 16; d++)
        read_txn(4'hD, 4'(d), {20'hFFBC0, 8'(s * 16 + d)}, 4'h0,
                 d == s, "R3", 19);
    end

    // every byte address, varied upper bits
    strap = 4'h3;
    for (int a = 0; a < 256; a++)
      read_txn(4'hD, 4'h3, {20'(a * 4099), 8'(a)}, 4'h0, 1'b1, "R7 sweep", 19);

    // openers other than 1101b
    for (int c = 0; c < 16; c++)
      if (c != 13) read_txn(4'(c), 4'h3, 28'h0000042, 4'h0, 1'b0, "R2", 19);

    // size nibble has no effect
    read_txn(4'hD, 4'h3, 28'hFF000A5, 4'h2, 1'b1, "R10", 19);
    cyc(1'b1, 1'b0, 4'hF); see(1'b0, 4'h0, "R10 idle after");
    read_txn(4'hD, 4'h3, 28'hFF000A6, 4'hF, 1'b1, "R10", 19);

    // early abort by a new opener in the address phase
    read_txn(4'hD, 4'h3, 28'h0000011, 4'h0, 1'b1, "R9 cut", 5);
    read_txn(4'hD, 4'h3, 28'h00000C7, 4'h0, 1'b1, "R9 restart", 19);

    // late abort while the target owns the lines
    read_txn(4'hD, 4'h3, 28'h0000033, 4'h0, 1'b1, "R9 late", 14);
    cyc(1'b0, 1'b0, 4'hF);
    cyc(1'b1, 1'b0, 4'hF); see(1'b0, 4'h0, "R9 released");
    cyc(1'b1, 1'b0, 4'hF); see(1'b0, 4'h0, "R9 stays idle");
    read_txn(4'hD, 4'h3, 28'h0000034, 4'h0, 1'b1, "R9 recover", 19);

    finish_run();
  end

endmodule